// File: doc/BRIEF.md
# Delayed Frame Responder Transmitter

This block answers completed request frames on a serial line. Each request arrives as a single-cycle strobe that carries a bit count and up to 16 data bits. Requests that are too short, and requests of the one length reserved for a short command, are discarded. Every other request is compared with a small table of known queries. A request that matches an entry in both length and value arms a reply.

Once a reply is armed, the block waits for a fixed turnaround. The turnaround is counted in ticks since the last reader rising edge, and an upstream receiver supplies that count as an input. The reply is then shifted out least significant bit first, with no line coding. Each bit is held for a fixed number of ticks. The tick enable paces all timing, so the block runs from whatever fast clock the chip provides. A busy flag covers the whole time from the match to the end of the last bit.

Top module: `frame_responder_tx`

## Requirements
- R1: After a synchronous reset, `tx_out` and `tx_busy` are both 0.
- R2: A request whose bit count is 4 or less starts no reply, and `tx_busy` stays 0.
- R3: A request whose bit count is exactly 6 starts no reply, whatever its data.
- R4: A 7-bit request with value 0x55 is answered with the 6-bit reply 0x3B.
- R5: A request starts a reply only if both its bit count and its data equal a table entry. For example, 7 bits with 0x54, and 8 bits with 0x55, give no reply.
- R6: The first reply bit appears on `tx_out` right after the first clock edge where `tick_en` is 1, `edge_age` is at least 490 and a reply is waiting.
- R7: Each reply bit is held on `tx_out` for 150 ticks. Bit 0 of the reply is sent first, and the bits are sent as they are, with no coding.
- R8: `tx_out` is 0 while a reply waits for its turnaround, and it returns to 0 when the last bit period ends.
- R9: `tx_busy` rises on the clock edge after an accepted request and falls on the edge that ends the last bit period.
- R10: Request strobes that arrive while `tx_busy` is 1 are dropped. They do not change the reply in progress and do not start a later one.
- R11: If `edge_age` is already at least 490 when a request matches, the first bit appears one tick after the match.
- R12: On cycles where `tick_en` is 0, neither the turnaround nor the bit timing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base enable; one tick per cycle where it is high |
| frm_valid | input | 1 | One-cycle strobe: a request frame is complete |
| frm_len | input | 5 | Bit count of the request |
| frm_data | input | 16 | Request bits, first received bit in bit 0 |
| edge_age | input | 12 | Ticks since the last reader rising edge |
| tx_out | output | 1 | Serial reply line |
| tx_busy | output | 1 | High from an accepted request until the reply ends |

## Verification
The hardest situation to reach is a request that matches after the turnaround point has already passed, so that the start is decided by the tick that follows rather than by the age threshold. The bench forces `edge_age` directly to a value above the threshold in the same cycle as the strobe. It also holds `tick_en` low in one run, which shows that the start then waits for the enable. A second hard case is a strobe that lands in the middle of a reply. The bench issues one such strobe during the turnaround wait and one during bit shifting. It then checks that the scoreboard sees an unchanged reply and that no second reply follows.

// File: rtl/frmresp_pkg.sv
package frmresp_pkg;

    localparam int LEN_W      = 5;
    localparam int DATA_W     = 16;
    localparam int AGE_W      = 12;
    localparam int TURN_TICKS = 490;
    localparam int BIT_TICKS  = 150;
    localparam int EMPTY_MAX  = 4;
    localparam int SKIP_LEN   = 6;
    localparam int N_ENTRIES  = 1;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND
    } tx_state_e;

    function automatic frame_t query_entry(input int idx);
        frame_t f;
        f = '0;
        case (idx)
            0: begin
                f.len  = LEN_W'(7);
                f.data = DATA_W'(16'h0055);
            end
            default: f = '0;
        endcase
        return f;
    endfunction

    function automatic frame_t reply_entry(input int idx);
        frame_t f;
        f = '0;
        case (idx)
            0: begin
                f.len  = LEN_W'(6);
                f.data = DATA_W'(16'h003B);
            end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/frame_lookup.sv
module frame_lookup
    import frmresp_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES
) (
    input  logic   clk,
    input  logic   rst,
    input  frame_t req,
    output logic   hit,
    output frame_t reply
);
    logic [ENTRIES-1:0] eq_vec;
    logic               eligible;

    assign eligible = (req.len > LEN_W'(EMPTY_MAX)) && (req.len != LEN_W'(SKIP_LEN));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        frame_t q;
        assign q         = query_entry(g);
        assign eq_vec[g] = (req.len == q.len) && (req.data == q.data);
    end

    always_comb begin
        hit   = 1'b0;
        reply = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq_vec[i] && eligible) begin
                hit   = 1'b1;
                reply = reply_entry(i);
            end
        end
    end

    assert_short_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (req.len <= LEN_W'(EMPTY_MAX)) |-> !hit);

    assert_skip_len_R3: assert property (@(posedge clk) disable iff (rst)
        (req.len == LEN_W'(SKIP_LEN)) |-> !hit);

endmodule

// File: rtl/reply_shifter.sv
module reply_shifter
    import frmresp_pkg::*;
#(
    parameter int TURN = TURN_TICKS,
    parameter int BITT = BIT_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load,
    input  frame_t           reply,
    input  logic [AGE_W-1:0] edge_age,
    output logic             tx_out,
    output logic             busy
);
    localparam int PER_W = $clog2(BITT);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  left;
    logic [PER_W-1:0]  per_cnt;
    logic              turn_ok;

    assign turn_ok = tick_en && (edge_age >= AGE_W'(TURN));
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            left    <= '0;
            per_cnt <= '0;
            tx_out  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tx_out <= 1'b0;
                    if (load) begin
                        state <= ST_WAIT;
                        shreg <= reply.data;
                        left  <= reply.len;
                    end
                end
                ST_WAIT: begin
                    if (turn_ok) begin
                        state   <= ST_SEND;
                        tx_out  <= shreg[0];
                        shreg   <= shreg >> 1;
                        left    <= left - LEN_W'(1);
                        per_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick_en) begin
                        if (per_cnt == PER_W'(BITT - 1)) begin
                            per_cnt <= '0;
                            if (left == '0) begin
                                state  <= ST_IDLE;
                                tx_out <= 1'b0;
                            end else begin
                                tx_out <= shreg[0];
                                shreg  <= shreg >> 1;
                                left   <= left - LEN_W'(1);
                            end
                        end else begin
                            per_cnt <= per_cnt + PER_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SEND) |-> !tx_out);

    assert_start_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && $past(state) == ST_WAIT) |->
            ($past(tick_en) && $past(edge_age) >= AGE_W'(TURN)));

    assert_tick_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_en) |=> ($stable(tx_out) && busy));

    assert_period_bound_R7: assert property (@(posedge clk) disable iff (rst)
        per_cnt < PER_W'(BITT));

endmodule

// File: rtl/frame_responder_tx.sv
module frame_responder_tx
    import frmresp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [AGE_W-1:0]  edge_age,
    output logic              tx_out,
    output logic              tx_busy
);
    frame_t req;
    frame_t reply;
    logic   hit;
    logic   load;

    assign req.len  = frm_len;
    assign req.data = frm_data;
    assign load     = frm_valid && hit && !tx_busy;

    frame_lookup #(.ENTRIES(N_ENTRIES)) u_lookup (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .hit   (hit),
        .reply (reply)
    );

    reply_shifter #(.TURN(TURN_TICKS), .BITT(BIT_TICKS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (load),
        .reply    (reply),
        .edge_age (edge_age),
        .tx_out   (tx_out),
        .busy     (tx_busy)
    );

    assert_load_busy_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> tx_busy);

    assert_drop_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && frm_valid && $past(tx_busy)) |=> (tx_busy || !tx_out));

endmodule

// File: tb/frame_responder_tx_tb.sv
module frame_responder_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TURN = 490;
    localparam int BITT = 150;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        frm_valid = 1'b0;
    logic [4:0]  frm_len = '0;
    logic [15:0] frm_data = '0;
    logic [11:0] edge_age;
    logic        tx_out;
    logic        tx_busy;

    int age = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int len;
        int data;
    } exp_t;
    exp_t expq[$];

    assign edge_age = (age > 4095) ? 12'hFFF : 12'(age);

    frame_responder_tx u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .frm_valid(frm_valid),
        .frm_len(frm_len), .frm_data(frm_data), .edge_age(edge_age),
        .tx_out(tx_out), .tx_busy(tx_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        if (tick_en) age = age + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (age %0d)", tag, act, exp, age);
        end
    endtask

    function automatic exp_t model(input int len, input int data);
        exp_t e;
        e.len = 0;
        e.data = 0;
        if (len == 7 && data == 'h55 && len > 4 && len != 6) begin
            e.len = 6;
            e.data = 'h3B;
        end
        return e;
    endfunction

    task automatic strobe(input int len, input int data);
        @(posedge clk); #2;
        frm_valid = 1'b1; frm_len = 5'(len); frm_data = 16'(data);
        @(posedge clk); #2;
        frm_valid = 1'b0;
    endtask

    task automatic send_frame(input int len, input int data);
        @(posedge clk); #2;
        age = 0;
        expq.push_back(model(len, data));
        frm_valid = 1'b1; frm_len = 5'(len); frm_data = 16'(data);
        @(posedge clk); #2;
        frm_valid = 1'b0;
    endtask

    task automatic wait_age(input int a);
        while (age < a) @(posedge clk);
    endtask

    // scoreboard monitor
    initial forever begin
        @(posedge clk); #1;
        if (!rst && age == TURN - 1 && expq.size() > 0) begin
            exp_t cur;
            cur = expq.pop_front();
            if (cur.len == 0) begin
                chk(tx_busy == 1'b0, "R2/R3/R5 no reply busy", int'(tx_busy), 0);
                @(posedge clk); #1;
                chk(tx_out == 1'b0, "R2/R3/R5 no reply line", int'(tx_out), 0);
            end else begin
                chk(tx_busy && !tx_out, "R8 R9 wait low busy", int'({tx_busy, tx_out}), 2);
                @(posedge clk); #1;
                chk(tx_out == cur.data[0], "R6 first bit at turnaround", int'(tx_out), cur.data & 1);
                for (int i = 0; i < cur.len; i++) begin
                    while (age < TURN + BITT*i + BITT/2) begin @(posedge clk); #1; end
                    chk(tx_out == cur.data[i], "R4 R7 reply bit", int'(tx_out), (cur.data >> i) & 1);
                end
                while (age < TURN + BITT*cur.len - 1) begin @(posedge clk); #1; end
                chk(tx_busy == 1'b1, "R9 busy through last period", int'(tx_busy), 1);
                @(posedge clk); #1;
                chk(!tx_busy && !tx_out, "R8 R9 end low idle", int'({tx_busy, tx_out}), 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #1;
        chk(!tx_out && !tx_busy, "R1 reset state", int'({tx_busy, tx_out}), 0);

        // scoreboard runs
        send_frame(3, 'h5);    wait_age(TURN + 200);   // R2
        send_frame(4, 'h5);    wait_age(TURN + 200);   // R2
        send_frame(6, 'h15);   wait_age(TURN + 200);   // R3
        send_frame(7, 'h54);   wait_age(TURN + 200);   // R5
        send_frame(8, 'h55);   wait_age(TURN + 200);   // R5
        send_frame(7, 'h55);   wait_age(TURN + BITT*6 + 20);  // R4

        // R10: strobes during wait and during shifting are dropped
        send_frame(7, 'h55);
        wait_age(100);  strobe(7, 'h55);
        wait_age(700);  strobe(7, 'h55);
        wait_age(TURN + BITT*6 + 40);
        chk(!tx_busy, "R10 no second reply", int'(tx_busy), 0);
        wait_age(TURN + BITT*6 + 600);
        chk(!tx_busy && !tx_out, "R10 still idle", int'({tx_busy, tx_out}), 0);

        // R11: late match starts next tick
        @(posedge clk); #2;
        age = 600;
        frm_valid = 1'b1; frm_len = 5'd7; frm_data = 16'h55;
        @(posedge clk); #1;
        chk(tx_busy && !tx_out, "R11 armed low", int'({tx_busy, tx_out}), 2);
        #1 frm_valid = 1'b0;
        @(posedge clk); #1;
        chk(tx_out == 1'b1, "R11 first bit next tick", int'(tx_out), 1);
        repeat (BITT*6 + 10) @(posedge clk);
        #1 chk(!tx_busy, "R11 done", int'(tx_busy), 0);

        // R12: no tick, no progress
        @(posedge clk); #2;
        tick_en = 1'b0;
        age = 600;
        frm_valid = 1'b1; frm_len = 5'd7; frm_data = 16'h55;
        @(posedge clk); #2;
        frm_valid = 1'b0;
        repeat (20) @(posedge clk);
        #1 chk(tx_busy && !tx_out, "R12 held while tick low", int'({tx_busy, tx_out}), 2);
        #1 tick_en = 1'b1;
        @(posedge clk); #1;
        chk(tx_out == 1'b1, "R12 resumes on tick", int'(tx_out), 1);
        repeat (BITT*6 + 10) @(posedge clk);
        #1 chk(!tx_busy && !tx_out, "R12 done", int'({tx_busy, tx_out}), 0);

        chk(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule